// File: doc/BRIEF.md
# Two-Stage Watchdog with Reset Routing

This block supervises software through a single 12-bit control word. Once enabled and restarted, a down-counter runs off a programmable prescaler. It starts from a power-of-two interval, and the interval select field chooses the exponent. When the counter first runs out, the block raises a warning flag and an optional interrupt, then reloads a short grace count and keeps running. If software does not restart the timer before the grace count also runs out, the block sets a sticky reset flag and issues a one-cycle reset request.

A small routing stage passes that request to the CPU reset output only while bit 0 of its own reset-control register is set. Two resets are used. A power-on reset clears everything. A core reset returns the control word to its default but keeps the reset flag, so software can still see after a core reset that the watchdog caused it.

Top module: `guard_timer`

## Requirements
- R1: After power-on reset the control word reads 0x400 (clock select 1, all else 0), and irq, resetReq and cpuReset are low.
- R2: The first expiry comes exactly D × 2^(BASE_SHIFT + 2·s) clock cycles after the write that sets restart (bit 0) with enable (bit 7). Here s is the interval select (bits 5:4), D is the divisor, and the interrupt flag is read at bit 3.
- R3: Clock select (bits 11:10) values 0..3 pick divisors of 2^DIV_SHIFT0..2^DIV_SHIFT3, which are 1, 256, 2048 and 65536 by default.
- R4: The first expiry sets the interrupt flag (bit 3). The irq output equals the interrupt flag ANDed with interrupt enable (bit 6).
- R5: When the flag is already set, a second expiry comes D × GRACE_CYCLES cycles after the first. If reset enable (bit 1) is set, this expiry sets the reset flag (bit 2) and raises resetReq for exactly one cycle.
- R6: If reset enable is clear, the second expiry leaves the reset flag clear and raises no resetReq.
- R7: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 there leaves the flag unchanged.
- R8: Restart reloads the full interval, even during the grace period, and leaves the interrupt flag as it is. Bit 0 always reads back 0.
- R9: Clearing enable without restart freezes the count. Setting enable again resumes from the frozen count.
- R10: A core reset makes the control word 0x400 but keeps the reset flag. A power-on reset clears it.
- R11: cpuReset equals resetReq only while the routing bit (routeWrData, latched by routeWrEn) is 1. Otherwise cpuReset stays 0.
- R12: The freeze-enable bit (bit 9) reads back as written, and bit 8 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| coreRstN | input | 1 | Core reset, active low, asynchronous |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 12 | Control word write value |
| rdData | output | 12 | Control word readback |
| routeWrEn | input | 1 | Routing register write strobe |
| routeWrData | input | 1 | Routing register bit 0 (allow CPU reset) |
| irq | output | 1 | Warning interrupt |
| resetReq | output | 1 | One-cycle reset request from the watchdog |
| cpuReset | output | 1 | Gated CPU reset |

## Verification
The hardest state to reach is a restart issued while the grace period is running. The interrupt flag must stay set and the full interval must replace the grace count, so the next expiry has to take the reset path and arrive at the full-interval distance, not the grace distance. The bench overrides the exponent, grace count and divisors to small values so that every path finishes in a few thousand cycles. It lands the restart write a fixed number of cycles after the warning and checks that no reset flag appears at the old grace point and that the request arrives exactly one full interval later. A core reset is applied while the reset flag is set, to show the flag outlives it.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int CTRL_W = 12;

  // control word bit positions (read and written by software)
  localparam int CLK_LO      = 10;
  localparam int CLK_HI      = 11;
  localparam int FREEZE_BIT  = 9;
  localparam int RSVD_BIT    = 8;
  localparam int EN_BIT      = 7;
  localparam int IE_BIT      = 6;
  localparam int SEL_LO      = 4;
  localparam int SEL_HI      = 5;
  localparam int IFLAG_BIT   = 3;
  localparam int RFLAG_BIT   = 2;
  localparam int RE_BIT      = 1;
  localparam int RESTART_BIT = 0;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 12'h400;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic       run;
    logic       loadFull;
    logic       loadGrace;
    logic [1:0] intvSel;
    logic [1:0] clkSel;
  } dpCmd_t;
endpackage

// File: rtl/gt_datapath.sv
module gt_datapath
  import guard_timer_pkg::*;
#(
  parameter int BASE_SHIFT   = 14,
  parameter int GRACE_CYCLES = 1024,
  parameter int DIV_SHIFT0   = 0,
  parameter int DIV_SHIFT1   = 8,
  parameter int DIV_SHIFT2   = 11,
  parameter int DIV_SHIFT3   = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   expire
);
  localparam int CNT_W = BASE_SHIFT + 7;
  localparam int MAX_A = (DIV_SHIFT0 > DIV_SHIFT1) ? DIV_SHIFT0 : DIV_SHIFT1;
  localparam int MAX_B = (DIV_SHIFT2 > DIV_SHIFT3) ? DIV_SHIFT2 : DIV_SHIFT3;
  localparam int MAX_SHIFT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PRE_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] fullVal;
  logic [CNT_W-1:0] graceVal;
  logic             tick;

  function automatic int divShift(input logic [1:0] s);
    case (s)
      2'd0:    return DIV_SHIFT0;
      2'd1:    return DIV_SHIFT1;
      2'd2:    return DIV_SHIFT2;
      default: return DIV_SHIFT3;
    endcase
  endfunction

  always_comb begin
    preLimit = PRE_W'((64'(1) << divShift(cmd.clkSel)) - 64'(1));
    fullVal  = CNT_W'(1) << (BASE_SHIFT + 2 * int'(cmd.intvSel));
    graceVal = CNT_W'(GRACE_CYCLES);
    tick     = cmd.run && (preCnt >= preLimit);
    expire   = tick && (count == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
    end else if (cmd.loadFull) begin
      preCnt <= '0;
      count  <= fullVal;
    end else if (cmd.loadGrace) begin
      preCnt <= '0;
      count  <= graceVal;
    end else if (cmd.run) begin
      if (tick) begin
        preCnt <= '0;
        if (count != '0) count <= count - CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/gt_ctrl.sv
module gt_ctrl
  import guard_timer_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              coreDomRstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              expire,
  output dpCmd_t            cmd,
  output logic [CTRL_W-1:0] rdData,
  output logic              irq,
  output logic              resetReq
);
  logic [1:0] clkSel;
  logic       freezeEn;
  logic       enable;
  logic       intEn;
  logic [1:0] intvSel;
  logic       rstEn;
  logic       intFlag;
  logic       rstFlag;
  logic       warnHit;
  logic       biteHit;
  logic       unusedWr;

  assign unusedWr = wrData[RSVD_BIT];

  always_comb begin
    warnHit       = expire && !intFlag;
    biteHit       = expire && intFlag && rstEn;
    cmd.run       = enable;
    cmd.loadFull  = wrEn && wrData[RESTART_BIT];
    cmd.loadGrace = warnHit;
    cmd.intvSel   = wrEn ? wrData[SEL_HI:SEL_LO] : intvSel;
    cmd.clkSel    = clkSel;
  end

  always_ff @(posedge clk or negedge coreDomRstN) begin
    if (!coreDomRstN) begin
      clkSel   <= CTRL_RESET[CLK_HI:CLK_LO];
      freezeEn <= 1'b0;
      enable   <= 1'b0;
      intEn    <= 1'b0;
      intvSel  <= 2'd0;
      rstEn    <= 1'b0;
      intFlag  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      if (wrEn) begin
        clkSel   <= wrData[CLK_HI:CLK_LO];
        freezeEn <= wrData[FREEZE_BIT];
        enable   <= wrData[EN_BIT];
        intEn    <= wrData[IE_BIT];
        intvSel  <= wrData[SEL_HI:SEL_LO];
        rstEn    <= wrData[RE_BIT];
      end
      if (warnHit) intFlag <= 1'b1;
      else if (wrEn && wrData[IFLAG_BIT]) intFlag <= 1'b0;
      resetReq <= biteHit;
    end
  end

  // reset flag lives in the power-on domain only
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) rstFlag <= 1'b0;
    else if (biteHit) rstFlag <= 1'b1;
    else if (wrEn && wrData[RFLAG_BIT]) rstFlag <= 1'b0;
  end

  always_comb begin
    rdData = {clkSel, freezeEn, 1'b0, enable, intEn, intvSel,
              intFlag, rstFlag, rstEn, 1'b0};
    irq    = intFlag && intEn;
  end
endmodule

// File: rtl/gt_route.sv
module gt_route (
  input  logic clk,
  input  logic porRstN,
  input  logic routeWrEn,
  input  logic routeWrData,
  input  logic resetReq,
  output logic cpuReset
);
  logic allowCpu;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) allowCpu <= 1'b0;
    else if (routeWrEn) allowCpu <= routeWrData;
  end

  assign cpuReset = resetReq && allowCpu;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int BASE_SHIFT   = 14,
  parameter int GRACE_CYCLES = 1024,
  parameter int DIV_SHIFT0   = 0,
  parameter int DIV_SHIFT1   = 8,
  parameter int DIV_SHIFT2   = 11,
  parameter int DIV_SHIFT3   = 16
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              coreRstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  input  logic              routeWrEn,
  input  logic              routeWrData,
  output logic              irq,
  output logic              resetReq,
  output logic              cpuReset
);
  dpCmd_t cmd;
  logic   expire;
  logic   coreDomRstN;

  assign coreDomRstN = porRstN && coreRstN;

  gt_ctrl u_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .coreDomRstN(coreDomRstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .expire     (expire),
    .cmd        (cmd),
    .rdData     (rdData),
    .irq        (irq),
    .resetReq   (resetReq)
  );

  gt_datapath #(
    .BASE_SHIFT  (BASE_SHIFT),
    .GRACE_CYCLES(GRACE_CYCLES),
    .DIV_SHIFT0  (DIV_SHIFT0),
    .DIV_SHIFT1  (DIV_SHIFT1),
    .DIV_SHIFT2  (DIV_SHIFT2),
    .DIV_SHIFT3  (DIV_SHIFT3)
  ) u_dp (
    .clk   (clk),
    .rstN  (coreDomRstN),
    .cmd   (cmd),
    .expire(expire)
  );

  gt_route u_route (
    .clk        (clk),
    .porRstN    (porRstN),
    .routeWrEn  (routeWrEn),
    .routeWrData(routeWrData),
    .resetReq   (resetReq),
    .cpuReset   (cpuReset)
  );
endmodule

// File: rtl/guard_timer_checker.sv
module guard_timer_checker (
  input logic clk,
  input logic porRstN,
  input logic coreRstN,
  input logic intFlagRd,
  input logic rstFlagRd,
  input logic intEnRd,
  input logic irq,
  input logic resetReq,
  input logic cpuReset
);
  // R5: request lasts one cycle
  p_req_one_cycle_r5: assert property (@(posedge clk) disable iff (!porRstN || !coreRstN)
    resetReq |=> !resetReq);

  // R5: request is accompanied by the reset flag
  p_req_sets_flag_r5: assert property (@(posedge clk) disable iff (!porRstN || !coreRstN)
    resetReq |-> rstFlagRd);

  // R5: a request only follows a pending warning
  p_req_after_warn_r5: assert property (@(posedge clk) disable iff (!porRstN || !coreRstN)
    resetReq |-> $past(intFlagRd));

  // R5: the reset flag only rises together with a request
  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!porRstN || !coreRstN)
    $rose(rstFlagRd) |-> resetReq);

  // R11: CPU reset never appears without a request
  p_route_gate_r11: assert property (@(posedge clk) disable iff (!porRstN || !coreRstN)
    cpuReset |-> resetReq);

  // R4: interrupt requires flag and enable
  p_irq_source_r4: assert property (@(posedge clk) disable iff (!porRstN || !coreRstN)
    irq |-> (intFlagRd && intEnRd));
endmodule

bind guard_timer guard_timer_checker u_checker (
  .clk      (clk),
  .porRstN  (porRstN),
  .coreRstN (coreRstN),
  .intFlagRd(rdData[3]),
  .rstFlagRd(rdData[2]),
  .intEnRd  (rdData[6]),
  .irq      (irq),
  .resetReq (resetReq),
  .cpuReset (cpuReset)
);

// File: tb/guard_timer_test.sv
module guard_timer_test;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        coreRstN = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] wrData = '0;
  logic [11:0] rdData;
  logic        routeWrEn = 1'b0;
  logic        routeWrData = 1'b0;
  logic        irq, resetReq, cpuReset;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  guard_timer #(
    .BASE_SHIFT(4), .GRACE_CYCLES(8),
    .DIV_SHIFT0(0), .DIV_SHIFT1(1), .DIV_SHIFT2(2), .DIV_SHIFT3(3)
  ) uut (
    .clk(clk), .porRstN(porRstN), .coreRstN(coreRstN),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .routeWrEn(routeWrEn), .routeWrData(routeWrData),
    .irq(irq), .resetReq(resetReq), .cpuReset(cpuReset)
  );

  typedef struct packed {
    logic [1:0]  clkSel;
    logic [1:0]  sel;
    logic        ie;
    logic        re;
    int unsigned firstCyc;
    int unsigned graceCyc;
  } vec_t;

  // expected: first = 2^(4+2*sel) * 2^clkSel, grace = 8 * 2^clkSel
  localparam vec_t VECS [5] = '{
    '{2'd0, 2'd0, 1'b1, 1'b1, 16,   8},
    '{2'd1, 2'd1, 1'b0, 1'b1, 128,  16},
    '{2'd2, 2'd0, 1'b1, 1'b0, 64,   32},
    '{2'd3, 2'd2, 1'b1, 1'b1, 2048, 64},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1024, 8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic writeCtrl(input logic [11:0] v);
    wrData = v;
    wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeRoute(input logic v);
    routeWrData = v;
    routeWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    routeWrEn = 1'b0;
  endtask

  task automatic porReset();
    porRstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic coreReset();
    coreRstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    coreRstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    porReset();
    // R1 reset state
    chk("R1 ctrl", 32'(rdData), 32'h400);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 resetReq", 32'(resetReq), 0);
    chk("R1 cpuReset", 32'(cpuReset), 0);

    // R12 freeze bit kept, bit 8 reads 0
    writeCtrl(12'h300);
    chk("R12 readback", 32'(rdData), 32'h200);

    // R8 restart bit reads 0
    writeCtrl(12'h081);
    chk("R8 restart reads 0", 32'(rdData), 32'h080);
    writeCtrl(12'h000);

    writeRoute(1'b1);

    for (int i = 0; i < 5; i++) begin
      vec_t v = VECS[i];
      writeCtrl({v.clkSel, 2'b00, 1'b1, v.ie, v.sel, 2'b11, v.re, 1'b1});
      waitCyc(int'(v.firstCyc) - 1);
      chk("R2 no early warning", 32'(rdData[3]), 0);
      waitCyc(1);
      chk("R2 R3 warning on time", 32'(rdData[3]), 1);
      chk("R4 irq gated", 32'(irq), 32'(v.ie));
      waitCyc(int'(v.graceCyc) - 1);
      chk("R5 no early reset flag", 32'(rdData[2]), 0);
      chk("R5 no early request", 32'(resetReq), 0);
      waitCyc(1);
      chk("R5 R6 request", 32'(resetReq), 32'(v.re));
      chk("R5 R6 reset flag", 32'(rdData[2]), 32'(v.re));
      chk("R11 cpu reset allowed", 32'(cpuReset), 32'(v.re));
      waitCyc(1);
      chk("R5 pulse ends", 32'(resetReq), 0);
    end

    // R9 pause and resume
    writeCtrl(12'h08D);
    waitCyc(5);
    writeCtrl(12'h000);
    waitCyc(20);
    chk("R9 frozen", 32'(rdData[3]), 0);
    writeCtrl(12'h080);
    waitCyc(9);
    chk("R9 resumed not yet", 32'(rdData[3]), 0);
    waitCyc(1);
    chk("R9 resumed expiry", 32'(rdData[3]), 1);

    // R8 restart inside grace period
    writeCtrl(12'h08F);
    waitCyc(16);
    chk("R8 warning before restart", 32'(rdData[3]), 1);
    waitCyc(3);
    writeCtrl(12'h083);
    chk("R8 flag kept on restart", 32'(rdData), 32'h08A);
    waitCyc(15);
    chk("R8 no reset at old grace point", 32'(rdData[2]), 0);
    chk("R8 no early request", 32'(resetReq), 0);
    waitCyc(1);
    chk("R8 full interval then request", 32'(resetReq), 1);
    chk("R11 cpu reset passes", 32'(cpuReset), 1);
    waitCyc(1);

    // R7 write-1-to-clear
    chk("R7 both flags", 32'(rdData), 32'h08E);
    writeCtrl(12'h082);
    chk("R7 zero keeps flags", 32'(rdData), 32'h08E);
    writeCtrl(12'h08A);
    chk("R7 clear warning only", 32'(rdData), 32'h086);

    // R10 core reset keeps reset flag
    coreReset();
    chk("R10 core reset", 32'(rdData), 32'h404);
    writeCtrl(12'h004);
    chk("R7 clear reset flag", 32'(rdData), 32'h000);

    // R11 routing blocked
    writeRoute(1'b0);
    writeCtrl(12'h08F);
    waitCyc(24);
    chk("R11 request present", 32'(resetReq), 1);
    chk("R11 cpu reset blocked", 32'(cpuReset), 0);
    waitCyc(1);

    // R10 power-on reset clears flag
    porReset();
    chk("R10 por clears flag", 32'(rdData), 32'h400);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule